// File: doc/BRIEF.md
# Serial Audio Receiver with Master/Slave Timing

This block takes a stereo stream from an external converter over three wires: a bit clock, a word select and serial data. It can run as a timing slave. In that case the converter drives the bit clock and word select, and the block only listens. It can also run as a timing master. In that case it derives the bit clock from an oversampling clock by integer division and drives word select itself. In both modes the serial data arrives on `sd_i`.

The receiver logic is clocked by the active bit clock, with the chosen sampling edge turned into a rising edge. It shifts each channel word in MSB first and keeps a programmable number of bits. It pairs a left word with the right word that follows it. A toggle handshake carries each finished pair into the system clock domain, where it appears with a one-cycle valid strobe. The bit clock has no phase or frequency relation to `sys_clk`. It must stay at or below 20 MHz, and `sys_clk` must be several times faster. Configuration inputs are quasi-static: change them only while `rst` is high.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, `sck_oe`, `ws_oe` and `pair_valid` are 0 and `left_data`/`right_data` are 0, whatever `cfg_master` is set to. The block comes out of reset as a timing slave and takes on master timing only after reset is released.
- R2: With `cfg_master`=1 held through reset, `sck_oe` and `ws_oe` go to 1 after release. `sck_o` then has a period of 2×`cfg_div` cycles of `os_clk`, with equal high and low phases.
- R3: A `cfg_div` value of 0 is treated as 1, which gives a bit-clock period of 2 `os_clk` cycles.
- R4: With `cfg_fall_edge`=0, `sd_i` is sampled on rising edges of the active bit clock. With `cfg_fall_edge`=1, it is sampled on falling edges.
- R5: In slave mode, `ws_i` is sampled on the same edge as `sd_i`. A channel word starts at the sampling edge where word select differs from its value at the previous sampling edge, and the data bit of that edge is the word's MSB.
- R6: In master mode, `ws_o` changes only at the bit-clock edge opposite the sampling edge. It toggles every H bit clocks, where H is `cfg_half` clamped to 16..32, so the frame length is 32..64.
- R7: Words are MSB first. The sample width W is `cfg_width` clamped to 16..32. The first W bits of a word are delivered right-aligned in bits W-1:0 with the upper bits zero. Later bits of the same word are dropped.
- R8: A word received with word select low is the left sample, and one received with word select high is the right sample. When the next high-to-low change of word select is sampled, the pair appears on `left_data`/`right_data` together with a `pair_valid` pulse that lasts exactly one `sys_clk` cycle. Both outputs then hold until the next pulse.
- R9: After reset, nothing is delivered until a left word that began at a word-select change seen after reset has been followed by a complete right word. An incomplete first frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, synchronous to sys_clk |
| os_clk | input | 1 | Oversampling clock used to generate the bit clock in master mode |
| cfg_master | input | 1 | 1 selects timing master, 0 selects timing slave |
| cfg_fall_edge | input | 1 | 0 samples on the rising bit-clock edge, 1 on the falling edge |
| cfg_div | input | 8 | Bit-clock half period in os_clk cycles (0 acts as 1) |
| cfg_width | input | 6 | Sample width, clamped to 16..32 |
| cfg_half | input | 6 | Bit clocks per word-select half in master mode, clamped to 16..32 |
| sck_i | input | 1 | Bit clock from the converter (slave mode) |
| sck_o | output | 1 | Generated bit clock (master mode) |
| sck_oe | output | 1 | Output enable for sck_o |
| ws_i | input | 1 | Word select from the converter (slave mode) |
| ws_o | output | 1 | Generated word select (master mode) |
| ws_oe | output | 1 | Output enable for ws_o |
| sd_i | input | 1 | Serial data |
| pair_valid | output | 1 | One-cycle strobe marking a new stereo pair |
| left_data | output | 32 | Left sample, right-aligned |
| right_data | output | 32 | Right sample, right-aligned |

## Verification
Assertions check the following on every clock of their domain:
- the generated word select moves only on the non-sampling phase transition;
- the divider count stays below its limit;
- the per-word bit count never passes the clamped width;
- the handshake toggle flips only at a high-to-low word-select change;
- `pair_valid` never lasts two cycles, and the outputs stay unchanged between strobes.

Only the bench scenarios can show the remaining behaviour. This includes correct values for both sampling edges and the width clamps, the dropped partial frame after reset, the bit-clock period for ordinary and zero divider settings, and the master-mode pairing of segments. The bench drives data only on the opposite edge, so sampling on the wrong edge would show up as corrupted words.

// File: rtl/asr_pkg.sv
package asr_pkg;

  // Clamp an unsigned value into the closed range [lo, hi].
  function automatic int unsigned clamp_u(input int unsigned v,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/asr_rst_sync.sv
// Reset bridge: asserts at once, releases after STAGES edges of clk.
module asr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) chain <= '1;
    else        chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/asr_clkgen.sv
// Master timing: bit-clock phase and word select, both in the os_clk domain.
// phase rising = sampling transition, phase falling = driving transition.
module asr_clkgen #(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned HCFG_W   = 6,
  parameter int unsigned HALF_MIN = 16,
  parameter int unsigned HALF_MAX = 32
) (
  input  logic              os_clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HCFG_W-1:0] cfg_half,
  output logic              phase,
  output logic              ws,
  output logic              master_q
);
  import asr_pkg::*;

  localparam logic [DIV_W-1:0]  DIV_ONE = DIV_W'(1);
  localparam logic [HCFG_W-1:0] HB_ONE  = HCFG_W'(1);

  logic [DIV_W-1:0]  div_eff, div_cnt;
  logic [HCFG_W-1:0] half_eff, bit_cnt;
  logic              tick, drive_edge;

  always_comb begin
    div_eff    = (cfg_div == '0) ? DIV_ONE : cfg_div;
    half_eff   = HCFG_W'(clamp_u(32'(cfg_half), HALF_MIN, HALF_MAX));
    tick       = master_q && (div_cnt == div_eff - DIV_ONE);
    drive_edge = tick && phase;
  end

  always_ff @(posedge os_clk or posedge rst) begin
    if (rst) begin
      master_q <= 1'b0;
      div_cnt  <= '0;
      phase    <= 1'b0;
      ws       <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      master_q <= cfg_master;
      if (master_q) begin
        if (tick) begin
          div_cnt <= '0;
          phase   <= ~phase;
        end else begin
          div_cnt <= div_cnt + DIV_ONE;
        end
        if (drive_edge) begin
          if (bit_cnt == half_eff - HB_ONE) begin
            bit_cnt <= '0;
            ws      <= ~ws;
          end else begin
            bit_cnt <= bit_cnt + HB_ONE;
          end
        end
      end
    end
  end

  // R6: word select only moves together with the driving transition
  assert_ws_drive_edge_R6: assert property (@(posedge os_clk) disable iff (rst)
    (ws != $past(ws)) |-> ($past(phase) && !phase));

  // R3: divider count stays below the effective limit (0 acts as 1)
  assert_div_range_R3: assert property (@(posedge os_clk) disable iff (rst)
    div_cnt < div_eff);
endmodule

// File: rtl/asr_deser.sv
// Bit-clock domain: word boundary detection, MSB-first shifting, pairing.
module asr_deser #(
  parameter int unsigned MAX_W  = 32,
  parameter int unsigned MIN_W  = 16,
  parameter int unsigned WCFG_W = 6
) (
  input  logic              rx_clk,
  input  logic              rst,
  input  logic [WCFG_W-1:0] cfg_width,
  input  logic              ws,
  input  logic              sd,
  output logic [MAX_W-1:0]  pub_left,
  output logic [MAX_W-1:0]  pub_right,
  output logic              pub_tgl
);
  import asr_pkg::*;

  localparam logic [WCFG_W-1:0] CNT_ONE = WCFG_W'(1);

  logic [WCFG_W-1:0] w_eff, bit_cnt;
  logic [MAX_W-1:0]  shreg, left_hold;
  logic              first, ws_prev, started, left_ok, ws_edge;

  always_comb begin
    w_eff   = WCFG_W'(clamp_u(32'(cfg_width), MIN_W, MAX_W));
    ws_edge = !first && (ws != ws_prev);
  end

  always_ff @(posedge rx_clk or posedge rst) begin
    if (rst) begin
      first     <= 1'b1;
      ws_prev   <= 1'b0;
      started   <= 1'b0;
      left_ok   <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      left_hold <= '0;
      pub_left  <= '0;
      pub_right <= '0;
      pub_tgl   <= 1'b0;
    end else begin
      first   <= 1'b0;
      ws_prev <= ws;
      if (ws_edge) begin
        shreg   <= {{(MAX_W-1){1'b0}}, sd};
        bit_cnt <= CNT_ONE;
        started <= 1'b1;
        if (started) begin
          if (ws) begin
            left_hold <= shreg;
            left_ok   <= 1'b1;
          end else if (left_ok) begin
            pub_left  <= left_hold;
            pub_right <= shreg;
            pub_tgl   <= ~pub_tgl;
            left_ok   <= 1'b0;
          end
        end
      end else if (bit_cnt < w_eff) begin
        shreg   <= {shreg[MAX_W-2:0], sd};
        bit_cnt <= bit_cnt + CNT_ONE;
      end
    end
  end

  // R7: never more than the clamped width of bits in one word
  assert_cnt_limit_R7: assert property (@(posedge rx_clk) disable iff (rst)
    bit_cnt <= w_eff);

  // R8: a pair is published only at a high-to-low word-select change
  assert_pub_on_fall_R8: assert property (@(posedge rx_clk) disable iff (rst)
    (pub_tgl != $past(pub_tgl)) |-> (!ws_prev && $past(ws_prev)));
endmodule

// File: rtl/asr_pair_sync.sv
// System domain: toggle synchroniser, capture of the stable pair, strobe.
module asr_pair_sync #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              rst,
  input  logic              src_tgl,
  input  logic [DATA_W-1:0] src_left,
  input  logic [DATA_W-1:0] src_right,
  output logic              valid,
  output logic [DATA_W-1:0] left,
  output logic [DATA_W-1:0] right
);
  logic [STAGES:0] chain;
  logic            seen;

  assign seen = chain[STAGES] ^ chain[STAGES-1];

  always_ff @(posedge sys_clk) begin
    if (rst) begin
      chain <= '0;
      valid <= 1'b0;
      left  <= '0;
      right <= '0;
    end else begin
      chain <= {chain[STAGES-1:0], src_tgl};
      valid <= seen;
      if (seen) begin
        left  <= src_left;
        right <= src_right;
      end
    end
  end

  // R8: strobe lasts a single cycle
  assert_valid_pulse_R8: assert property (@(posedge sys_clk) disable iff (rst)
    valid |=> !valid);

  // R8: outputs hold between strobes
  assert_hold_R8: assert property (@(posedge sys_clk) disable iff (rst)
    !valid |-> ($stable(left) && $stable(right)));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int unsigned MAX_W       = 32,
  parameter int unsigned MIN_W       = 16,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned HALF_MIN    = 16,
  parameter int unsigned HALF_MAX    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WCFG_W      = $clog2(MAX_W + 1),
  parameter int unsigned HCFG_W      = $clog2(HALF_MAX + 1)
) (
  input  logic              sys_clk,
  input  logic              rst,
  input  logic              os_clk,
  input  logic              cfg_master,
  input  logic              cfg_fall_edge,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [WCFG_W-1:0] cfg_width,
  input  logic [HCFG_W-1:0] cfg_half,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              ws_i,
  output logic              ws_o,
  output logic              ws_oe,
  input  logic              sd_i,
  output logic              pair_valid,
  output logic [MAX_W-1:0]  left_data,
  output logic [MAX_W-1:0]  right_data
);
  logic             rst_os, rst_rx, rx_clk;
  logic             gen_phase, gen_ws, gen_master;
  logic             ws_sel;
  logic [MAX_W-1:0] pub_left, pub_right;
  logic             pub_tgl;

  asr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_os (
    .clk(os_clk), .rst_in(rst), .rst_out(rst_os));

  asr_clkgen #(
    .DIV_W(DIV_W), .HCFG_W(HCFG_W), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
  ) u_clkgen (
    .os_clk(os_clk), .rst(rst_os), .cfg_master(cfg_master),
    .cfg_div(cfg_div), .cfg_half(cfg_half),
    .phase(gen_phase), .ws(gen_ws), .master_q(gen_master));

  assign sck_o  = gen_phase ^ cfg_fall_edge;
  assign ws_o   = gen_ws;
  assign sck_oe = gen_master;
  assign ws_oe  = gen_master;

  // Sampling edge becomes the rising edge of rx_clk in both modes.
  assign rx_clk = (gen_master ? sck_o : sck_i) ^ cfg_fall_edge;
  assign ws_sel = gen_master ? gen_ws : ws_i;

  asr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_rx (
    .clk(rx_clk), .rst_in(rst), .rst_out(rst_rx));

  asr_deser #(.MAX_W(MAX_W), .MIN_W(MIN_W), .WCFG_W(WCFG_W)) u_deser (
    .rx_clk(rx_clk), .rst(rst_rx), .cfg_width(cfg_width),
    .ws(ws_sel), .sd(sd_i),
    .pub_left(pub_left), .pub_right(pub_right), .pub_tgl(pub_tgl));

  asr_pair_sync #(.DATA_W(MAX_W), .STAGES(SYNC_STAGES)) u_pair_sync (
    .sys_clk(sys_clk), .rst(rst), .src_tgl(pub_tgl),
    .src_left(pub_left), .src_right(pub_right),
    .valid(pair_valid), .left(left_data), .right(right_data));
endmodule

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  logic        sys_clk = 1'b0, os_clk = 1'b0, rst = 1'b1;
  logic        cfg_master = 1'b0, cfg_fall_edge = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [5:0]  cfg_width = 6'd16, cfg_half = 6'd16;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic        sck_o, sck_oe, ws_o, ws_oe, pair_valid;
  logic [31:0] left_data, right_data;

  audio_serial_rx uut (
    .sys_clk(sys_clk), .rst(rst), .os_clk(os_clk),
    .cfg_master(cfg_master), .cfg_fall_edge(cfg_fall_edge),
    .cfg_div(cfg_div), .cfg_width(cfg_width), .cfg_half(cfg_half),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .ws_i(ws_i), .ws_o(ws_o), .ws_oe(ws_oe), .sd_i(sd_i),
    .pair_valid(pair_valid), .left_data(left_data), .right_data(right_data));

  always #2 sys_clk = ~sys_clk;   // 250 MHz
  always #5 os_clk  = ~os_clk;
  localparam int SCK_HALF = 30;   // slave bit clock ~16.7 MHz

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] exp_l [16], exp_r [16], segword [16];
  int n_exp = 0, n_got = 0;
  bit prev_valid = 1'b0;
  // master-mode driver state
  bit master_drv = 1'b0, m_fall = 1'b0, last_ws = 1'b0;
  int m_w = 16, m_h = 16, seg = 0, bitidx = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rand_word(input int w);
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    return $urandom & m;
  endfunction

  // pair monitor
  always @(negedge sys_clk) begin
    if (pair_valid) begin
      if (prev_valid) check(1'b0, "R8 strobe longer than one cycle", 1, 0);
      if (n_got < n_exp) begin
        check(left_data == exp_l[n_got], "R8/R7 left sample", left_data, exp_l[n_got]);
        check(right_data == exp_r[n_got], "R8/R7 right sample", right_data, exp_r[n_got]);
      end else begin
        check(1'b0, "R9 unexpected pair", n_got, n_exp);
      end
      n_got++;
    end
    prev_valid = pair_valid;
  end

  // master: ws must change only while bit clock sits at the driving level (R6)
  always @(ws_o) begin
    if (master_drv) begin
      #1;
      check(sck_o == m_fall, "R6 ws_o moved on sampling edge", sck_o, m_fall);
    end
  end

  // master: drive data on the non-sampling transition
  always @(sck_o) begin
    if (master_drv && sck_o == m_fall) begin
      #1;
      if (ws_o != last_ws) begin
        if (seg >= 1) check(bitidx == m_h, "R6 bit clocks per ws half", bitidx, m_h);
        if (seg < 15) seg++;
        bitidx  = 0;
        last_ws = ws_o;
      end
      sd_i = (bitidx < m_w) ? segword[seg][m_w-1-bitidx] : 1'($urandom);
      bitidx++;
    end
  end

  // watchdog
  always @(posedge sys_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic apply_reset(input bit mst, input bit fall, input logic [7:0] div,
                             input logic [5:0] wid, input logic [5:0] half);
    rst = 1'b1;
    master_drv = 1'b0;
    cfg_master = mst; cfg_fall_edge = fall; cfg_div = div;
    cfg_width = wid; cfg_half = half;
    sck_i = fall; ws_i = 1'b0; sd_i = 1'b0;
    repeat (8) @(posedge sys_clk);
  endtask

  task automatic send_word(input bit wsv, input logic [31:0] w, input int wbits,
                           input int nbits, input bit fall);
    for (int i = 0; i < nbits; i++) begin
      sck_i = fall;
      ws_i  = wsv;
      sd_i  = (i < wbits) ? w[wbits-1-i] : 1'($urandom);
      #SCK_HALF;
      sck_i = ~fall;
      #SCK_HALF;
    end
  endtask

  task automatic run_slave(input bit fall, input logic [5:0] cfgw, input int weff,
                           input int half, input int frames, input string tag);
    apply_reset(1'b0, fall, 8'd1, cfgw, 6'd16);
    for (int f = 0; f < frames; f++) begin
      exp_l[f] = rand_word(weff);
      exp_r[f] = rand_word(weff);
    end
    n_exp = frames; n_got = 0;
    @(negedge sys_clk) rst = 1'b0;
    // R9: incomplete left followed by a right must not be delivered
    send_word(1'b0, $urandom, weff, 5, fall);
    send_word(1'b1, $urandom, weff, half, fall);
    for (int f = 0; f < frames; f++) begin
      send_word(1'b0, exp_l[f], weff, half, fall);
      send_word(1'b1, exp_r[f], weff, half, fall);
    end
    send_word(1'b0, 32'h0, weff, 3, fall);
    repeat (60) @(posedge sys_clk);
    @(negedge sys_clk);
    check(n_got == frames, tag, n_got, frames);
  endtask

  task automatic run_master(input bit fall, input logic [7:0] div, input int diveff,
                            input logic [5:0] cfghalf, input int heff, input int w,
                            input string ptag);
    int c;
    bit prevs;
    apply_reset(1'b1, fall, div, 6'(w), cfghalf);
    sck_i = 1'b0;
    for (int k = 0; k < 16; k++) segword[k] = rand_word(w);
    for (int k = 0; k < 3; k++) begin
      exp_l[k] = segword[2*k+2];
      exp_r[k] = segword[2*k+3];
    end
    n_exp = 3; n_got = 0;
    m_fall = fall; m_w = w; m_h = heff; seg = 0; bitidx = 0; last_ws = 1'b0;
    @(negedge sys_clk) rst = 1'b0;
    master_drv = 1'b1;
    repeat (4) @(posedge os_clk);
    #1;
    check(sck_oe == 1'b1, "R2 sck_oe in master mode", sck_oe, 1);
    check(ws_oe == 1'b1, "R2 ws_oe in master mode", ws_oe, 1);
    // bit-clock period in os_clk cycles
    @(posedge sck_o);
    #1;
    c = 0; prevs = 1'b1;
    while (c < 1000) begin
      @(posedge os_clk);
      #1;
      c++;
      if (sck_o && !prevs) break;
      prevs = sck_o;
    end
    check(c == 2*diveff, ptag, c, 2*diveff);
    wait (seg >= 8);
    repeat (60) @(posedge sys_clk);
    @(negedge sys_clk);
    master_drv = 1'b0;
    check(n_got == 3, "R8 master-mode pair count", n_got, 3);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    // R1: reset state even with master requested
    apply_reset(1'b1, 1'b0, 8'd2, 6'd24, 6'd32);
    @(negedge sys_clk);
    check(sck_oe == 1'b0, "R1 sck_oe during reset", sck_oe, 0);
    check(ws_oe == 1'b0, "R1 ws_oe during reset", ws_oe, 0);
    check(pair_valid == 1'b0, "R1 pair_valid during reset", pair_valid, 0);
    check(left_data == 32'h0 && right_data == 32'h0, "R1 data during reset",
          {left_data, right_data}, 0);

    // R4 R5 R7 R9: slave, rising edge, 24-bit samples in 32-bit halves
    run_slave(1'b0, 6'd24, 24, 32, 5, "R9 slave rise pair count");
    // R4: slave, falling edge, 16-bit samples filling 16-bit halves
    run_slave(1'b1, 6'd16, 16, 16, 5, "R4 slave fall pair count");
    // R7: width above range clamps to 32
    run_slave(1'b0, 6'd45, 32, 32, 4, "R7 width clamp high pair count");
    // R7: width below range clamps to 16, extra bits dropped
    run_slave(1'b1, 6'd5, 16, 20, 4, "R7 width clamp low pair count");

    // R2 R6: master, rising sampling edge, divide 3, 20-bit halves
    run_master(1'b0, 8'd3, 3, 6'd20, 20, 16, "R2 sck_o period");
    // R3 R6: divider 0, falling sampling edge, half clamped 50 -> 32
    run_master(1'b1, 8'd0, 1, 6'd50, 32, 32, "R3 sck_o period with div 0");

    rst = 1'b1;
    repeat (4) @(posedge sys_clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule